// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block manages a bank of general-purpose pins (sixteen by default) behind a 32-bit word-addressed register port. Each pin can be an input or an output. It can also be handed to an alternate function, in which case the block stops driving its pad. The block only produces the pad control lines (drive value and drive enable) and a select line for the alternate-function mux. The tristate pad cells and the alternate logic sit outside it.

Every pin's input passes through a two-flop synchronizer and can raise an interrupt. A pin can be set to detect a high level, a low level, a rising edge, a falling edge or any edge. Detected events land in a sticky status register. Reading that register returns its contents and clears it, and writing it ORs bits back in. A mask, changed only through separate set and clear addresses, selects which status bits reach the single `irq` output. Software typically unmasks the pins it services and reads the status register from its handler. It can write back any edge events it wants to keep pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word addresses are: 0 direction, 1 output enable, 2 output value, 3 input value (read only), 4 bypass, 5 mask (read only), 6 mask-set, 7 mask-clear, 8 status, 9 detect type, 10 polarity, 11 any-edge. Bit i of each register belongs to pin i. Addresses 6 and 7 read back the mask.
- R2: After reset, direction reads all ones (input), output enable, output value, bypass, type, polarity, any-edge and status read 0, the mask reads all ones, and `irq` and `pad_oe` are 0.
- R3: Writing mask-set ORs the written bits into the mask. Writing mask-clear removes them. Zero bits in either write leave the mask unchanged.
- R4: `pad_oe[i]` is 1 only when direction bit i is 0, output enable bit i is 1 and bypass bit i is 0. `pad_out[i]` equals output value bit i when bypass bit i is 0.
- R5: The input value register returns `pad_in` after two clock edges of synchronization.
- R6: With type bit 1, a pin whose synchronized input equals its polarity bit (1 high, 0 low) sets its status bit on every cycle. A read that clears the status is therefore followed by the bit being set again while the level persists.
- R7: With type bit 0 and any-edge bit 0, polarity 1 selects rising edges and 0 falling edges. The status bit is set on the third clock edge after the pad changes.
- R8: With type bit 0 and any-edge bit 1, both edges set the status bit whatever the polarity bit is.
- R9: Status bits are sticky. A read of address 8 returns the status and clears it. An event that arrives in the same cycle as that read is not lost and shows in the status afterwards.
- R10: A write to address 8 ORs the written bits into the status.
- R11: `irq` is 1 exactly when some status bit is set and its mask bit is 0.
- R12: A pin with bypass bit 1 has `pad_oe` and `pad_out` at 0, `alt_sel` at 1, and raises no status events.
- R13: Read data appears on `bus_rdata` one cycle after `bus_rd`. Unmapped addresses read 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPIN | Raw pad inputs |
| pad_out | output | NPIN | Pad drive values |
| pad_oe | output | NPIN | Pad drive enables |
| alt_sel | output | NPIN | Alternate-function select per pin |
| irq | output | 1 | Aggregate interrupt |

## Verification
The read that clears the status register can land in the same clock cycle as a freshly detected edge. The bench provokes this by raising a pad and then issuing the status read so that it is sampled on exactly the edge at which the synchronized edge event is registered. It judges the collision by requiring that the read returns the old, empty status and that a second read returns the new event bit. A level-mode pin gives a second case: clear and re-set compete on every cycle, and the bit must be back immediately after the clearing read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR  = 4'd0,
        RA_OE   = 4'd1,
        RA_OUT  = 4'd2,
        RA_IN   = 4'd3,
        RA_BYP  = 4'd4,
        RA_MASK = 4'd5,
        RA_MSET = 4'd6,
        RA_MCLR = 4'd7,
        RA_STAT = 4'd8,
        RA_TYPE = 4'd9,
        RA_POL  = 4'd10,
        RA_ANY  = 4'd11
    } reg_addr_e;

    // per-pin detection setup
    typedef struct packed {
        logic byp;   // pin owned by alternate function
        logic lvl;   // 1: level, 0: edge
        logic pol;   // 1: high/rising, 0: low/falling
        logic any;   // edge mode: both edges
    } pin_mode_t;

    function automatic logic pin_event(input logic cur, input logic prv,
                                       input pin_mode_t m);
        logic rise, fall, edge_hit;
        rise     = cur & ~prv;
        fall     = ~cur & prv;
        edge_hit = m.any ? (rise | fall) : (m.pol ? rise : fall);
        if (m.byp)
            return 1'b0;
        return m.lvl ? (cur == m.pol) : edge_hit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prv    <= '0;
        end else begin
            meta_q <= din;
            cur    <= meta_q;
            prv    <= cur;
        end
    end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
    parameter int NPIN = 16
) (
    input  logic [NPIN-1:0] dir_in,
    input  logic [NPIN-1:0] oe,
    input  logic [NPIN-1:0] outv,
    input  logic [NPIN-1:0] byp,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = ~byp[i] & ~dir_in[i] & oe[i];
            pad_out[i] = ~byp[i] & outv[i];
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic      [NPIN-1:0]  cur,
    input  logic      [NPIN-1:0]  prv,
    input  pin_mode_t [NPIN-1:0]  mode,
    input  logic      [NPIN-1:0]  mask_set,
    input  logic      [NPIN-1:0]  mask_clr,
    input  logic                  stat_clr,
    input  logic      [NPIN-1:0]  stat_or,
    output logic      [NPIN-1:0]  status,
    output logic      [NPIN-1:0]  mask,
    output logic                  irq
);
    logic [NPIN-1:0] evt;

    for (genvar i = 0; i < NPIN; i++) begin : g_det
        assign evt[i] = pin_event(cur[i], prv[i], mode[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '1;
            status <= '0;
        end else begin
            mask   <= (mask | mask_set) & ~mask_clr;
            // new events win over a clearing read in the same cycle
            status <= (stat_clr ? '0 : status) | evt | stat_or;
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   alt_sel,
    output logic              irq
);
    reg_addr_e        addr;
    logic [NPIN-1:0]  wd;
    logic [NPIN-1:0]  dir_q, oe_q, out_q, byp_q, typ_q, pol_q, any_q;
    logic [NPIN-1:0]  cur_w, prv_w, mask_w, status_w;
    pin_mode_t [NPIN-1:0] mode_w;
    logic [NPIN-1:0]  rd_mux;

    assign addr = reg_addr_e'(bus_addr);
    assign wd   = bus_wdata[NPIN-1:0];

    if (NPIN < DATA_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = |bus_wdata[DATA_W-1:NPIN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            oe_q  <= '0;
            out_q <= '0;
            byp_q <= '0;
            typ_q <= '0;
            pol_q <= '0;
            any_q <= '0;
        end else if (bus_wr) begin
            case (addr)
                RA_DIR:  dir_q <= wd;
                RA_OE:   oe_q  <= wd;
                RA_OUT:  out_q <= wd;
                RA_BYP:  byp_q <= wd;
                RA_TYPE: typ_q <= wd;
                RA_POL:  pol_q <= wd;
                RA_ANY:  any_q <= wd;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_mode
        assign mode_w[i] = '{byp: byp_q[i], lvl: typ_q[i],
                             pol: pol_q[i], any: any_q[i]};
    end

    gpio_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pad_in),
        .cur (cur_w),
        .prv (prv_w)
    );

    gpio_irq_unit #(.NPIN(NPIN)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur_w),
        .prv      (prv_w),
        .mode     (mode_w),
        .mask_set ((bus_wr && addr == RA_MSET) ? wd : '0),
        .mask_clr ((bus_wr && addr == RA_MCLR) ? wd : '0),
        .stat_clr (bus_rd && addr == RA_STAT),
        .stat_or  ((bus_wr && addr == RA_STAT) ? wd : '0),
        .status   (status_w),
        .mask     (mask_w),
        .irq      (irq)
    );

    gpio_pad_drv #(.NPIN(NPIN)) u_pad (
        .dir_in  (dir_q),
        .oe      (oe_q),
        .outv    (out_q),
        .byp     (byp_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign alt_sel = byp_q;

    always_comb begin
        case (addr)
            RA_DIR:                    rd_mux = dir_q;
            RA_OE:                     rd_mux = oe_q;
            RA_OUT:                    rd_mux = out_q;
            RA_IN:                     rd_mux = cur_w;
            RA_BYP:                    rd_mux = byp_q;
            RA_MASK, RA_MSET, RA_MCLR: rd_mux = mask_w;
            RA_STAT:                   rd_mux = status_w;
            RA_TYPE:                   rd_mux = typ_q;
            RA_POL:                    rd_mux = pol_q;
            RA_ANY:                    rd_mux = any_q;
            default:                   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= DATA_W'(rd_mux);
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPIN-1:0]  pad_oe,
    input logic [NPIN-1:0]  alt_sel,
    input logic [NPIN-1:0]  mask_q,
    input logic [NPIN-1:0]  status_q,
    input logic             irq
);
    assert_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '1 && status_q == '0 && !irq && pad_oe == '0));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_MSET) |=>
        ((mask_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_MCLR) |=>
        ((mask_q & $past(bus_wdata[NPIN-1:0])) == '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == RA_STAT) |=>
        ((status_q & $past(status_q)) == $past(status_q)));

    assert_status_or_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_STAT && !bus_rd) |=>
        ((status_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    assert_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q != '0));

    assert_no_drive_R12: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & alt_sel) == '0);

    assert_unmapped_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr > RA_ANY) |=> (bus_rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .alt_sel   (alt_sel),
    .mask_q    (mask_w),
    .status_q  (status_w),
    .irq       (irq)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out, pad_oe, alt_sel;
    logic              irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN)) u0 (.*);

    // op(1: read-compare, 0: write), addr(4), data(32)
    localparam int NVEC = 20;
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b0, 4'd9,  32'h0000_00FF}, {1'b1, 4'd9,  32'h0000_00FF},
        {1'b0, 4'd10, 32'h0000_A55A}, {1'b1, 4'd10, 32'h0000_A55A},
        {1'b0, 4'd11, 32'h0000_0F0F}, {1'b1, 4'd11, 32'h0000_0F0F},
        {1'b0, 4'd1,  32'hABCD_0003}, {1'b1, 4'd1,  32'h0000_0003},
        {1'b0, 4'd7,  32'h0000_00F0}, {1'b1, 4'd5,  32'h0000_FF0F},
        {1'b0, 4'd6,  32'h0000_0030}, {1'b1, 4'd6,  32'h0000_FF3F},
        {1'b0, 4'd7,  32'h0000_0000}, {1'b1, 4'd7,  32'h0000_FF3F},
        {1'b0, 4'd6,  32'h0000_FFFF}, {1'b1, 4'd5,  32'h0000_FFFF},
        {1'b0, 4'd9,  32'h0000_0000}, {1'b0, 4'd10, 32'h0000_0000},
        {1'b0, 4'd11, 32'h0000_0000}, {1'b0, 4'd1,  32'h0000_0000}
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        logic [31:0] junk;
        cyc(4);
        brd(4'd8, junk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R2 reset state
        check("R2 irq", {31'b0, irq}, 0);
        check("R2 pad_oe", 32'(pad_oe), 0);
        brd(4'd0, rd); check("R2 dir", rd, 32'h0000_FFFF);
        brd(4'd5, rd); check("R2 mask", rd, 32'h0000_FFFF);
        brd(4'd8, rd); check("R2 status", rd, 0);
        brd(4'd4, rd); check("R2 bypass", rd, 0);

        // R1 / R3 register map and mask set/clear walk
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][36]) begin
                brd(VEC[k][35:32], rd);
                check("R1/R3 table", rd, VEC[k][31:0]);
            end else
                bwr(VEC[k][35:32], VEC[k][31:0]);
        end
        settle();

        // R4 pad drive
        bwr(4'd0, 32'h0000_FFF0);
        bwr(4'd1, 32'h0000_0007);
        bwr(4'd2, 32'h0000_0005);
        check("R4 pad_oe", 32'(pad_oe), 32'h7);
        check("R4 pad_out", 32'(pad_out), 32'h5);
        // R12 bypass pin 0
        bwr(4'd4, 32'h0000_0001);
        check("R12 pad_oe", 32'(pad_oe), 32'h6);
        check("R12 pad_out", 32'(pad_out), 32'h4);
        check("R12 alt_sel", 32'(alt_sel), 32'h1);
        bwr(4'd4, 0);

        // R5 input sync
        pad_in = 16'hA5A5;
        cyc(2);
        brd(4'd3, rd); check("R5 input", rd, 32'h0000_A5A5);
        bwr(4'd3, 32'h0000_FFFF);                    // R13 ignored write
        brd(4'd3, rd); check("R13 input write ignored", rd, 32'h0000_A5A5);
        brd(4'd15, rd); check("R13 unmapped", rd, 0);
        pad_in = '0;
        settle();

        // R7 rising edge on pin 4, latency
        bwr(4'd10, 32'h10);
        bwr(4'd7, 32'h10);
        pad_in[4] = 1'b1;
        cyc(2); check("R7 not yet", {31'b0, irq}, 0);
        cyc(1); check("R7 rise irq", {31'b0, irq}, 1);
        brd(4'd8, rd); check("R7 rise status", rd, 32'h10);
        check("R9 cleared irq", {31'b0, irq}, 0);
        pad_in[4] = 1'b0;
        cyc(3);
        brd(4'd8, rd); check("R7 fall ignored", rd, 0);

        // R7 falling edge with polarity 0
        bwr(4'd10, 0);
        pad_in[4] = 1'b1; settle();
        pad_in[4] = 1'b0; cyc(3);
        brd(4'd8, rd); check("R7 fall status", rd, 32'h10);

        // R8 any edge overrides polarity
        bwr(4'd11, 32'h10);
        bwr(4'd10, 32'h10);
        pad_in[4] = 1'b1; cyc(3);
        brd(4'd8, rd); check("R8 any rise", rd, 32'h10);
        pad_in[4] = 1'b0; cyc(3);
        brd(4'd8, rd); check("R8 any fall", rd, 32'h10);
        bwr(4'd11, 0);

        // R6 level high on pin 5
        bwr(4'd9, 32'h20);
        bwr(4'd10, 32'h30);
        bwr(4'd7, 32'h20);
        pad_in[5] = 1'b1; cyc(3);
        check("R6 level irq", {31'b0, irq}, 1);
        brd(4'd8, rd); check("R6 level status", rd, 32'h20);
        brd(4'd8, rd); check("R6 level reasserts", rd, 32'h20);
        pad_in[5] = 1'b0; cyc(3);
        brd(4'd8, rd);
        brd(4'd8, rd); check("R6 level released", rd, 0);
        bwr(4'd9, 0);
        settle();

        // R10 / R11 status write and mask gating
        bwr(4'd8, 32'h100);
        check("R11 masked", {31'b0, irq}, 0);
        bwr(4'd7, 32'h100);
        check("R11 unmasked", {31'b0, irq}, 1);
        bwr(4'd6, 32'h100);
        check("R11 remasked", {31'b0, irq}, 0);
        brd(4'd8, rd); check("R10 status or", rd, 32'h100);

        // R9 clearing read collides with a new edge event
        pad_in[4] = 1'b1;
        cyc(2);
        brd(4'd8, rd); check("R9 collide old", rd, 0);
        brd(4'd8, rd); check("R9 collide kept", rd, 32'h10);

        // R12 bypass suppresses events
        pad_in[4] = 1'b0; settle();
        bwr(4'd4, 32'h10);
        pad_in[4] = 1'b1; cyc(3);
        check("R12 bypass irq", {31'b0, irq}, 0);
        brd(4'd8, rd); check("R12 bypass status", rd, 0);

        finish_run();
    end
endmodule